// File: doc/BRIEF.md
# GPIO Expander Register Bank with Auto-Incrementing Pointer

This block is the register bank of a serial-attached GPIO expander. It sits behind a byte-level serial slave front end. That front end reports four events: transaction start (including a repeated start), stop, each received write byte, and each request for a byte to send. The bank holds one internal pointer.

In a write transaction, the first byte loads the pointer. Every later byte lands in the register the pointer names, and the pointer then moves on by one. Each byte that is read also moves the pointer on by one. A read at a chosen address is therefore a write transaction that carries only the address, followed by a repeated start and a run of reads.

The map has four parts:
- eight pin-level input registers, whose read value passes through a per-port inversion byte;
- eight output registers that drive the port latches;
- eight interrupt-status registers that are cleared when read;
- a set of configuration registers. Some of them are banked per port and chosen through a port-select register. The others are single global registers.

Top module: `gpio_regbank`

## Requirements
- R1: After reset:
  - output registers 08h–0Fh read FFh and `out_port` is all ones;
  - for every port, the banked mask (19h) and pull-up (1Dh) bytes read FFh;
  - 2Ah reads FFh, 2Bh reads 80h, 2Ch reads FFh and 2Eh reads 20h;
  - every other stored register reads 00h;
  - `irq_n` is high.
- R2: The first `wr_valid` byte after reset, after `txn_start` or after `txn_stop` loads the pointer and is stored in no register.
- R3: Each later write byte in the same transaction is stored at the pointer, and the pointer then advances by one.
- R4: `rd_data` always shows the register at the pointer. Each `rd_req` advances the pointer by one. With no address written since reset, reads start at 00h. A stop keeps the pointer.
- R5: The pointer advances from 30h, or from any loaded value above 30h, to 00h.
- R6: Reading address 00h+p returns pin byte p (`pin_in[8p+7:8p]`) XOR the inversion byte of port p (banked register 1Bh). Writes to 00h–07h are ignored.
- R7: Port select at 18h stores only the low three bits and reads the upper bits as zero. It chooses which port's copy of the banked registers 19h–23h is written and read.
- R8: Addresses 24h–27h and above 30h read 00h and discard writes. Address 2Eh always reads 20h and ignores writes.
- R9: A status bit of port p is set one clock edge after pin bit p changes, but only while the banked mask bit (19h, 1 = masked) is clear. `irq_n` is low while any status bit is set. Writes to 10h–17h are ignored.
- R10: A read (`rd_req`) of status register 10h+p clears that port's status bits. A pin change sampled at the same edge as that read leaves its own bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | One-cycle pulse on start or repeated start |
| txn_stop | input | 1 | One-cycle pulse on stop |
| wr_valid | input | 1 | One-cycle pulse: a write byte is present on `wr_data` |
| wr_data | input | 8 | Received write byte |
| rd_req | input | 1 | One-cycle pulse: the byte on `rd_data` is being sent |
| rd_data | output | 8 | Register at the current pointer (combinational) |
| pin_in | input | 64 | Pin levels, byte p belongs to port p |
| out_port | output | 64 | Output register contents, byte p for port p |
| irq_n | output | 1 | Low while any interrupt-status bit is set |

## Verification
A read that clears interrupt status and a pin change that sets status can fall on the same clock edge. The bench provokes this by raising `rd_req` on status register 11h in the same cycle that it toggles an unmasked pin of port 1. The byte sent must be the old status. After that edge, only the newly changed bit may remain, which is seen both on `irq_n` and on a second read of 11h. Address loading and data writes also meet at the pointer wrap point, and the bench judges this by reading back across the 30h-to-00h boundary.

// File: rtl/gpio_regbank_pkg.sv
// Package: address map, reset values and pointer stepping shared by the
// register bank. Assumes an 8-bit pointer and eight ports of eight pins.
package gpio_regbank_pkg;
    localparam int NPORTS = 8;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int PIN_W  = NPORTS * BYTE_W;
    localparam int NBANK  = 11;   // banked registers 19h..23h
    localparam int NFLAT  = 9;    // global registers 28h..30h

    localparam logic [PTR_W-1:0] A_OUT      = 8'h08;
    localparam logic [PTR_W-1:0] A_STAT     = 8'h10;
    localparam logic [PTR_W-1:0] A_SEL      = 8'h18;
    localparam logic [PTR_W-1:0] A_BANK     = 8'h19;
    localparam logic [PTR_W-1:0] A_BANK_END = 8'h23;
    localparam logic [PTR_W-1:0] A_FLAT     = 8'h28;
    localparam logic [PTR_W-1:0] A_ID       = 8'h2E;
    localparam logic [PTR_W-1:0] A_LAST     = 8'h30;
    localparam logic [BYTE_W-1:0] DEV_ID    = 8'h20;

    localparam int BK_MASK   = 0;
    localparam int BK_INV    = 2;
    localparam int BK_PULLUP = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // Reset value of banked register b.
    function automatic byte_t bank_reset(int b);
        return (b == BK_MASK || b == BK_PULLUP) ? 8'hFF : 8'h00;
    endfunction

    // Reset value of global register f (index from 28h).
    function automatic byte_t flat_reset(int f);
        case (f)
            2, 4:    return 8'hFF;
            3:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    // Next pointer value, wrapping after the last mapped address.
    function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p);
        return (p >= A_LAST) ? '0 : p + 8'd1;
    endfunction
endpackage

// File: rtl/rb_pointer.sv
// Register pointer: the first write byte of a transaction loads it, and every
// data byte or read request advances it. Assumes the front end never pulses
// wr_valid and rd_req in the same cycle.
module rb_pointer
    import gpio_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_stop,
    input  logic             wr_valid,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             rd_req,
    output logic [PTR_W-1:0] ptr,
    output logic             addr_phase,
    output logic             wr_en
);
    // A data write happens only once the address byte has been taken.
    assign wr_en = wr_valid && !addr_phase;

    // Load, advance and address-phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            addr_phase <= 1'b1;
        end else begin
            if (wr_valid && addr_phase)
                ptr <= wr_data;
            else if (wr_en || rd_req)
                ptr <= ptr_step(ptr);

            if (txn_start || txn_stop)
                addr_phase <= 1'b1;
            else if (wr_valid)
                addr_phase <= 1'b0;
        end
    end
endmodule

// File: rtl/rb_irq_port.sv
// Interrupt status of one port: latches unmasked pin changes and clears on
// a read of its register. A change seen at the clearing edge survives.
module rb_irq_port
    import gpio_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  byte_t       pin,
    input  byte_t       mask,
    input  logic        clr,
    output byte_t       status
);
    byte_t pin_q;
    byte_t change;

    // Edges on unmasked pins since the previous clock.
    assign change = (pin ^ pin_q) & ~mask;

    // Pin history and sticky status with clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= pin;
            status <= '0;
        end else begin
            pin_q  <= pin;
            status <= (clr ? '0 : status) | change;
        end
    end
endmodule

// File: rtl/rb_config.sv
// Writable registers: output latches, port select, the per-port bank at
// 19h..23h and the global block at 28h..30h. Gives the read value for the
// addresses it owns and zero for all other addresses.
module rb_config
    import gpio_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] addr,
    input  byte_t            wr_data,
    output logic [PIN_W-1:0] out_port,
    output logic [PIN_W-1:0] inv_flat,
    output logic [PIN_W-1:0] mask_flat,
    output byte_t            cfg_rdata
);
    byte_t      out_q  [NPORTS];
    byte_t      bank_q [NBANK][NPORTS];
    byte_t      flat_q [NFLAT];
    logic [2:0] sel_q;

    // Output latches, written at 08h..0Fh.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (!rst_n)
                out_q[p] <= 8'hFF;
            else if (wr_en && addr == A_OUT + 8'(p))
                out_q[p] <= wr_data;
        end
    end

    // Port select keeps only the port number.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en && addr == A_SEL)
            sel_q <= wr_data[2:0];
    end

    // Banked registers: the selected port's copy takes the write.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBANK; b++) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (!rst_n)
                    bank_q[b][p] <= bank_reset(b);
                else if (wr_en && addr == A_BANK + 8'(b) && sel_q == 3'(p))
                    bank_q[b][p] <= wr_data;
            end
        end
    end

    // Global registers; the identity slot is never written.
    always_ff @(posedge clk) begin
        for (int f = 0; f < NFLAT; f++) begin
            if (!rst_n)
                flat_q[f] <= flat_reset(f);
            else if (wr_en && addr == A_FLAT + 8'(f) && addr != A_ID)
                flat_q[f] <= wr_data;
        end
    end

    // Pack per-port views for the outputs and the status logic.
    for (genvar p = 0; p < NPORTS; p++) begin : g_pack
        assign out_port [p*BYTE_W +: BYTE_W] = out_q[p];
        assign inv_flat [p*BYTE_W +: BYTE_W] = bank_q[BK_INV][p];
        assign mask_flat[p*BYTE_W +: BYTE_W] = bank_q[BK_MASK][p];
    end

    // Read selection for the addresses owned here.
    always_comb begin
        logic [3:0] boff;
        logic [3:0] foff;
        boff      = 4'(addr - A_BANK);
        foff      = 4'(addr - A_FLAT);
        cfg_rdata = '0;
        if (addr >= A_OUT && addr < A_STAT)
            cfg_rdata = out_q[addr[2:0]];
        else if (addr == A_SEL)
            cfg_rdata = {5'b0, sel_q};
        else if (addr >= A_BANK && addr <= A_BANK_END)
            cfg_rdata = bank_q[boff][sel_q];
        else if (addr == A_ID)
            cfg_rdata = DEV_ID;
        else if (addr >= A_FLAT && addr <= A_LAST)
            cfg_rdata = flat_q[foff];
    end
endmodule

// File: rtl/gpio_regbank.sv
// Top of the register bank. Combines the pointer, the configuration storage
// and per-port interrupt status, and forms the read byte. Assumes one-cycle
// event pulses from a byte-level serial front end.
module gpio_regbank
    import gpio_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_stop,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             rd_req,
    output logic [7:0]       rd_data,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] out_port,
    output logic             irq_n
);
    logic [PTR_W-1:0] ptr;
    logic             addr_phase;
    logic             wr_en;
    logic [PIN_W-1:0] inv_flat;
    logic [PIN_W-1:0] mask_flat;
    byte_t            cfg_rdata;
    byte_t            pin_b  [NPORTS];
    byte_t            inv_b  [NPORTS];
    byte_t            stat_b [NPORTS];
    logic [NPORTS-1:0] stat_any;

    rb_pointer u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .ptr        (ptr),
        .addr_phase (addr_phase),
        .wr_en      (wr_en)
    );

    rb_config u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (ptr),
        .wr_data   (wr_data),
        .out_port  (out_port),
        .inv_flat  (inv_flat),
        .mask_flat (mask_flat),
        .cfg_rdata (cfg_rdata)
    );

    // One status block per port, cleared by a read of its own register.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign pin_b[p]    = pin_in[p*BYTE_W +: BYTE_W];
        assign inv_b[p]    = inv_flat[p*BYTE_W +: BYTE_W];
        assign stat_any[p] = |stat_b[p];

        rb_irq_port u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_b[p]),
            .mask   (mask_flat[p*BYTE_W +: BYTE_W]),
            .clr    (rd_req && ptr == A_STAT + 8'(p)),
            .status (stat_b[p])
        );
    end

    assign irq_n = ~|stat_any;

    // Read byte: inverted pins, status, or configuration.
    always_comb begin
        if (ptr < A_OUT)
            rd_data = pin_b[ptr[2:0]] ^ inv_b[ptr[2:0]];
        else if (ptr >= A_STAT && ptr < A_SEL)
            rd_data = stat_b[ptr[2:0]];
        else
            rd_data = cfg_rdata;
    end
endmodule

// File: rtl/gpio_regbank_chk.sv
// Checker for gpio_regbank: pointer stepping, reset state, protection of
// output latches from address and input-port bytes, and reserved reads.
module gpio_regbank_chk
    import gpio_regbank_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             rd_req,
    input logic [PTR_W-1:0] ptr,
    input logic             addr_phase,
    input logic [7:0]       rd_data,
    input logic [PIN_W-1:0] out_port
);
    assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> out_port == '1);

    assert_addr_byte_not_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && addr_phase |=> $stable(out_port));

    assert_read_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !wr_valid && $past(rst_n) |=>
            ptr == (($past(ptr) >= A_LAST) ? 8'h00 : $past(ptr) + 8'd1));

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !wr_valid && ptr == A_LAST |=> ptr == 8'h00);

    assert_input_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !addr_phase && ptr < A_OUT |=> $stable(out_port));

    assert_reserved_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr > A_BANK_END && ptr < A_FLAT) || ptr > A_LAST) |-> rd_data == 8'h00);
endmodule

bind gpio_regbank gpio_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .ptr        (ptr),
    .addr_phase (addr_phase),
    .rd_data    (rd_data),
    .out_port   (out_port)
);

// File: tb/tb_gpio_regbank.sv
// Directed bench for gpio_regbank: one task per scenario, each checking
// its own results against values derived from the requirements.
module tb_gpio_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0, txn_stop = 1'b0;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [63:0] pin_in = 64'h8877_6655_4433_2211;
    logic [63:0] out_port;
    logic        irq_n;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regbank dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_data(rd_data), .pin_in(pin_in), .out_port(out_port), .irq_n(irq_n)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); txn_start = 1'b1;
        @(posedge clk); #1 txn_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); txn_stop = 1'b1;
        @(posedge clk); #1 txn_stop = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(posedge clk); #1 wr_valid = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); rd_req = 1'b1;
        #1 b = rd_data;
        @(posedge clk); #1 rd_req = 1'b0;
    endtask

    task automatic write_at(input logic [7:0] a, input logic [7:0] d);
        pulse_start(); wr_byte(a); wr_byte(d); pulse_stop();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        pulse_start(); wr_byte(a); pulse_start(); rd_byte(d); pulse_stop();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 out_port", out_port, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1 irq_n", irq_n, 1);
        pulse_start(); rd_byte(v); pulse_stop();
        check("R4 read without address starts at 00h", v, 8'h11);
        read_at(8'h08, v); check("R1 output 08h", v, 8'hFF);
        read_at(8'h19, v); check("R1 mask 19h", v, 8'hFF);
        read_at(8'h1D, v); check("R1 pull-up 1Dh", v, 8'hFF);
        read_at(8'h1B, v); check("R1 inversion 1Bh", v, 8'h00);
        read_at(8'h2A, v); check("R1 period 2Ah", v, 8'hFF);
        read_at(8'h2B, v); check("R1 width 2Bh", v, 8'h80);
        read_at(8'h2C, v); check("R1 divider 2Ch", v, 8'hFF);
        read_at(8'h2E, v); check("R1 identity 2Eh", v, 8'h20);
    endtask

    task automatic t_write_seq();
        logic [7:0] v;
        pulse_start(); wr_byte(8'h08); wr_byte(8'hA5); wr_byte(8'h5A); wr_byte(8'h3C); pulse_stop();
        check("R2 R3 out_port after burst", out_port, 64'hFFFF_FFFF_FF3C_5AA5);
        pulse_start(); wr_byte(8'h08); pulse_start();
        rd_byte(v); check("R4 seq read 08h", v, 8'hA5);
        rd_byte(v); check("R4 seq read 09h", v, 8'h5A);
        rd_byte(v); check("R4 seq read 0Ah", v, 8'h3C);
        pulse_stop();
        pulse_start(); rd_byte(v); pulse_stop();
        check("R4 stop keeps pointer (0Bh)", v, 8'hFF);
    endtask

    task automatic t_input_inv();
        logic [7:0] v;
        write_at(8'h18, 8'h02);
        write_at(8'h1B, 8'hF0);
        read_at(8'h02, v); check("R6 inverted port 2", v, 8'hC3);
        read_at(8'h00, v); check("R6 port 0 not inverted", v, 8'h11);
        pulse_start(); wr_byte(8'h02); wr_byte(8'h00); wr_byte(8'h00); pulse_stop();
        read_at(8'h02, v); check("R6 write to 02h ignored", v, 8'hC3);
        read_at(8'h03, v); check("R6 write to 03h ignored", v, 8'h44);
        check("R6 outputs untouched", out_port, 64'hFFFF_FFFF_FF3C_5AA5);
    endtask

    task automatic t_port_sel();
        logic [7:0] v;
        write_at(8'h18, 8'h0B);
        read_at(8'h18, v); check("R7 select keeps low 3 bits", v, 8'h03);
        read_at(8'h1B, v); check("R7 port 3 inversion", v, 8'h00);
        write_at(8'h18, 8'h02);
        read_at(8'h1B, v); check("R7 port 2 inversion", v, 8'hF0);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        write_at(8'h24, 8'h77);
        read_at(8'h24, v); check("R8 reserved 24h", v, 8'h00);
        read_at(8'h31, v); check("R8 beyond map 31h", v, 8'h00);
        write_at(8'h2E, 8'h55);
        read_at(8'h2E, v); check("R8 identity read-only", v, 8'h20);
        write_at(8'h12, 8'h99);
        read_at(8'h12, v); check("R9 status write ignored", v, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        pulse_start(); wr_byte(8'h2F); wr_byte(8'hAB); wr_byte(8'hCD); wr_byte(8'h99); pulse_stop();
        pulse_start(); wr_byte(8'h2F); pulse_start();
        rd_byte(v); check("R3 2Fh", v, 8'hAB);
        rd_byte(v); check("R5 30h", v, 8'hCD);
        rd_byte(v); check("R5 wrap to 00h", v, 8'h11);
        pulse_stop();
        pulse_start(); wr_byte(8'hFF); pulse_start();
        rd_byte(v); check("R8 loaded FFh reads zero", v, 8'h00);
        rd_byte(v); check("R5 FFh steps to 00h", v, 8'h11);
        pulse_stop();
    endtask

    task automatic t_irq();
        logic [7:0] v;
        @(negedge clk); pin_in[0] = ~pin_in[0];
        @(posedge clk); #1 check("R9 masked change no irq", irq_n, 1);
        read_at(8'h10, v); check("R9 masked status 10h", v, 8'h00);
        write_at(8'h18, 8'h01);
        write_at(8'h19, 8'h00);
        @(negedge clk); pin_in[11] = ~pin_in[11];
        @(posedge clk); #1 check("R9 unmasked change irq low", irq_n, 0);
        read_at(8'h11, v); check("R9 status 11h", v, 8'h08);
        check("R10 cleared after read", irq_n, 1);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        @(negedge clk); pin_in[8] = ~pin_in[8];
        @(posedge clk); #1;
        pulse_start(); wr_byte(8'h11); pulse_start();
        @(negedge clk); rd_req = 1'b1; pin_in[13] = ~pin_in[13];
        #1 v = rd_data;
        @(posedge clk); #1 rd_req = 1'b0;
        check("R10 read returns old status", v, 8'h01);
        check("R10 new change keeps irq", irq_n, 0);
        pulse_stop();
        read_at(8'h11, v); check("R10 only new bit survives", v, 8'h20);
        check("R10 irq released", irq_n, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_write_seq();
        t_input_inv();
        t_port_sel();
        t_reserved();
        t_wrap();
        t_irq();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule